// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block gathers the sectors of a multi-sector erase. The first decoded sector-erase write marks its sector in an eleven-bit selection map and opens a loading window of fixed length. Each later sector-erase write that arrives while the window is open adds its sector and restarts the window. When the window runs out, the block raises a one-cycle start pulse for the erase engine and sets its status bit, which then stays high until the engine reports completion.

Any other decoded command written while the window is open cancels the whole operation and empties the map. An erase-suspend strobe during the window closes it at once and starts the erase, so that the engine can suspend straight away. After the erase has started, the block ignores all writes. The sector address comes from the top six array address bits. A parameter selects the boot arrangement: in the top-boot map the small sectors sit at the high end of the 512 KB array, and in the bottom-boot map they sit at the low end. The window length is the clock frequency in MHz times the window time in microseconds, counted in clock cycles.

Top module: `sector_erase_window`

## Requirements
- R1: During and right after reset, `sel_map` is all zero, and `q3` and `erase_go` are 0.
- R2: In the idle state, a sector-erase write sets exactly the map bit of the decoded sector, and `q3` stays 0.
- R3: With TOP_BOOT=1, address bits [18:13] decode as follows. Any value with bits [18:16] below 7 gives sector bits[18:16] (64 KB each). 111_0xx gives sector 7. 111_100 gives sector 8. 111_101 gives sector 9. 111_11x gives sector 10.
- R4: With TOP_BOOT=0, address bits [18:13] decode as follows. 000_00x gives sector 0. 000_010 gives sector 1. 000_011 gives sector 2. 000_1xx gives sector 3. Any value with bits [18:16] nonzero gives sector bits[18:16]+3.
- R5: If no sector-erase write is accepted for W cycles (W = CLK_MHZ*WIN_US), the block leaves the window. `erase_go` is 1 for exactly the one cycle after the W-th edge that follows the last accepted write, and `q3` becomes 1 in that same cycle.
- R6: Each sector-erase write accepted in the window adds its sector and restarts the count. A write presented on the W-th edge after the previous one is still accepted.
- R7: Any other write during the window aborts the operation, including one on the same edge as a sector-erase write. The map clears, `q3` stays 0, and no `erase_go` follows.
- R8: While `q3`=1, sector-erase writes, other writes and suspend strobes leave `sel_map` and `q3` unchanged.
- R9: A suspend strobe during the window ends it on that edge. `erase_go` and `q3` are 1 in the next cycle, and the map keeps its sectors.
- R10: A sector-erase write for a sector already selected leaves the map unchanged, but it still restarts the window.
- R11: `erase_done` while `q3`=1 clears `sel_map` and `q3` on the next edge.
- R12: In the idle state, other writes and suspend strobes have no effect: the map stays zero and `q3` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| se_wr | input | 1 | Decoded sector-erase (30h) write strobe |
| se_addr_hi | input | 6 | Array address bits [18:13] of that write |
| other_wr | input | 1 | Any other decoded command write |
| susp_wr | input | 1 | Erase-suspend strobe |
| erase_done | input | 1 | Erase engine has finished |
| sel_map | output | 11 | Sectors selected for erase, bit n = sector n |
| q3 | output | 1 | 0 while loading or idle, 1 once erase has begun |
| erase_go | output | 1 | One-cycle erase start pulse |

## Verification
Every result is registered, so the bench drives each write for one clock edge and reads the outputs at the next falling edge. It sees a new sector in `sel_map`, a cleared map after an abort or a done strobe, and the start after a suspend one cycle after the write. The start at timeout is due exactly W edges after the last accepted load. The bench reads the outputs after W-1 quiet cycles, where the start must still be absent, and again one cycle later, where the pulse must be present. It reads once more after that to confirm the pulse lasts only one cycle. Reload cases count W again from the edge of the reloading write.

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
  parameter int NSECT    = 11,
  parameter bit TOP_BOOT = 1'b1,
  parameter int CLK_MHZ  = 250,
  parameter int WIN_US   = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_wr,
  input  logic [5:0]       se_addr_hi,
  input  logic             other_wr,
  input  logic             susp_wr,
  input  logic             erase_done,
  output logic [NSECT-1:0] sel_map,
  output logic             q3,
  output logic             erase_go
);
  localparam int WINDOW_CYC = CLK_MHZ * WIN_US;
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WINDOW_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_WIN, S_RUN} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [NSECT-1:0] hit;

  function automatic logic [3:0] sect_of(input logic [5:0] a);
    if (TOP_BOOT) begin
      if (a[5:3] != 3'd7) return {1'b0, a[5:3]};
      else if (!a[2])     return 4'd7;
      else if (!a[1])     return a[0] ? 4'd9 : 4'd8;
      else                return 4'd10;
    end else begin
      if (a[5:3] != 3'd0) return {1'b0, a[5:3]} + 4'd3;
      else if (a[2])      return 4'd3;
      else if (a[1])      return a[0] ? 4'd2 : 4'd1;
      else                return 4'd0;
    end
  endfunction

  assign hit = {{(NSECT-1){1'b0}}, 1'b1} << sect_of(se_addr_hi);
  assign q3  = (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sel_map  <= '0;
      cnt      <= '0;
      erase_go <= 1'b0;
    end else begin
      erase_go <= 1'b0;
      case (st)
        S_IDLE:
          if (se_wr && !other_wr) begin
            sel_map <= sel_map | hit;
            cnt     <= RELOAD;
            st      <= S_WIN;
          end
        S_WIN:
          if (other_wr) begin
            sel_map <= '0;
            st      <= S_IDLE;
          end else begin
            if (se_wr) sel_map <= sel_map | hit;
            if (susp_wr || (!se_wr && cnt == '0)) begin
              st       <= S_RUN;
              erase_go <= 1'b1;
            end else if (se_wr) cnt <= RELOAD;
            else cnt <= cnt - 1'b1;
          end
        S_RUN:
          if (erase_done) begin
            sel_map <= '0;
            st      <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_erase_window_check.sv
module sector_erase_window_check #(
  parameter int NSECT = 11,
  parameter int WIN   = 12500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             se_wr,
  input logic             other_wr,
  input logic             susp_wr,
  input logic             erase_done,
  input logic [NSECT-1:0] sel_map,
  input logic             q3,
  input logic             erase_go
);
  localparam int GW = $clog2(WIN + 2) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (se_wr && !q3 && !other_wr) gap <= '0;
    else if (gap <= GW'(WIN)) gap <= gap + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (sel_map == '0 && !q3 && !erase_go));
  p_load_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (se_wr && !other_wr && !q3) |=> (sel_map != '0));
  p_go_at_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (q3 && (gap == GW'(WIN) || $past(susp_wr))));
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n) erase_go |=> !erase_go);
  p_q3_needs_go_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(q3) |-> erase_go);
  p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && !q3) |=> (sel_map == '0 && !q3 && !erase_go));
  p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q3 && !erase_done) |=> (q3 && $stable(sel_map)));
  p_susp_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_wr && !other_wr && !q3 && sel_map != '0) |=> erase_go);
  p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (q3 && erase_done) |=> (sel_map == '0 && !q3));
endmodule

bind sector_erase_window sector_erase_window_check #(.NSECT(NSECT), .WIN(WINDOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .se_wr(se_wr), .other_wr(other_wr), .susp_wr(susp_wr),
  .erase_done(erase_done), .sel_map(sel_map), .q3(q3), .erase_go(erase_go)
);

// File: tb/sector_erase_window_bench.sv
module sector_erase_window_bench;
  localparam int W = 50;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se_wr = 1'b0, other_wr = 1'b0, susp_wr = 1'b0, erase_done = 1'b0;
  logic [5:0] se_addr_hi = '0;
  logic [10:0] map_t, map_b;
  logic q3_t, q3_b, go_t, go_b;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sector_erase_window #(.TOP_BOOT(1'b1), .CLK_MHZ(1), .WIN_US(W)) u_sector_erase_window (
    .clk(clk), .rst_n(rst_n), .se_wr(se_wr), .se_addr_hi(se_addr_hi), .other_wr(other_wr),
    .susp_wr(susp_wr), .erase_done(erase_done), .sel_map(map_t), .q3(q3_t), .erase_go(go_t));

  sector_erase_window #(.TOP_BOOT(1'b0), .CLK_MHZ(1), .WIN_US(W)) u_sector_erase_window_bot (
    .clk(clk), .rst_n(rst_n), .se_wr(se_wr), .se_addr_hi(se_addr_hi), .other_wr(other_wr),
    .susp_wr(susp_wr), .erase_done(erase_done), .sel_map(map_b), .q3(q3_b), .erase_go(go_b));

  // {address[18:0], top-boot sector, bottom-boot sector}
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {19'h00000, 4'd0, 4'd0}, {19'h03FFF, 4'd0, 4'd0}, {19'h04000, 4'd0, 4'd1},
    {19'h06000, 4'd0, 4'd2}, {19'h08000, 4'd0, 4'd3}, {19'h0F000, 4'd0, 4'd3},
    {19'h10000, 4'd1, 4'd4}, {19'h2FFFF, 4'd2, 4'd5}, {19'h3A000, 4'd3, 4'd6},
    {19'h40000, 4'd4, 4'd7}, {19'h5ABCD, 4'd5, 4'd8}, {19'h6FFFF, 4'd6, 4'd9},
    {19'h70000, 4'd7, 4'd10}, {19'h77FFF, 4'd7, 4'd10}, {19'h78000, 4'd8, 4'd10},
    {19'h7A000, 4'd9, 4'd10}, {19'h7C000, 4'd10, 4'd10}, {19'h7FFFF, 4'd10, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic se, input logic [18:0] addr, input logic oth,
                      input logic sus, input logic dn);
    se_wr = se; se_addr_hi = addr[18:13]; other_wr = oth; susp_wr = sus; erase_done = dn;
    @(negedge clk);
    se_wr = 1'b0; other_wr = 1'b0; susp_wr = 1'b0; erase_done = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 map", {map_t, map_b}, '0);
    check("R1 q3/go", {q3_t, q3_b, go_t, go_b}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {map_t, q3_t, go_t}, '0);

    // R2/R3/R4 decode table, each load aborted by another write (R7)
    for (int v = 0; v < NV; v++) begin
      step(1'b1, VEC[v][26:8], 1'b0, 1'b0, 1'b0);
      check("R3 top map", map_t, 11'd1 << VEC[v][7:4]);
      check("R4 bottom map", map_b, 11'd1 << VEC[v][3:0]);
      check("R2 q3 low", {q3_t, q3_b}, 2'b00);
      step(1'b0, '0, 1'b1, 1'b0, 1'b0);
      check("R7 abort clears", {map_t, map_b, q3_t, go_t}, '0);
    end

    // R12 idle other/suspend ignored
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R12 idle ignore", {map_t, q3_t, go_t}, '0);

    // R5 timeout and one-cycle pulse; R8 ignore while running; R11 done
    step(1'b1, 19'h10000, 1'b0, 1'b0, 1'b0);
    idle(W - 1);
    check("R5 no go before W", {q3_t, go_t}, 2'b00);
    idle(1);
    check("R5 go at W", {q3_t, go_t, q3_b, go_b}, 4'b1111);
    idle(1);
    check("R5 go one cycle", {q3_t, go_t}, 2'b10);
    step(1'b1, 19'h40000, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R8 map held", map_t, 11'h002);
    check("R8 q3 held", {q3_t, go_t}, 2'b10);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);
    check("R11 done clears", {map_t, q3_t, map_b, q3_b}, '0);

    // R6 reload on the W-th edge
    step(1'b1, 19'h00000, 1'b0, 1'b0, 1'b0);
    idle(W - 1);
    step(1'b1, 19'h7A000, 1'b0, 1'b0, 1'b0);
    check("R6 late load accepted", map_t, 11'h201);
    check("R6 window still open", {q3_t, go_t}, 2'b00);
    idle(W - 1);
    check("R6 restarted count", {q3_t, go_t}, 2'b00);
    idle(1);
    check("R6 go after reload", {q3_t, go_t}, 2'b11);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);

    // R10 repeat of a selected sector reloads but leaves map
    step(1'b1, 19'h20000, 1'b0, 1'b0, 1'b0);
    idle(20);
    step(1'b1, 19'h2F000, 1'b0, 1'b0, 1'b0);
    check("R10 map unchanged", map_t, 11'h004);
    idle(W - 1);
    check("R10 window reloaded", {q3_t, go_t}, 2'b00);
    idle(1);
    check("R10 go", {q3_t, go_t}, 2'b11);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);

    // R9 suspend closes the window early
    step(1'b1, 19'h60000, 1'b0, 1'b0, 1'b0);
    idle(10);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0);
    check("R9 suspend starts", {q3_t, go_t}, 2'b11);
    check("R9 map kept", map_t, 11'h040);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1);

    // R7 abort on same edge as a load, no go afterwards
    step(1'b1, 19'h50000, 1'b0, 1'b0, 1'b0);
    idle(5);
    step(1'b1, 19'h30000, 1'b1, 1'b0, 1'b0);
    check("R7 simultaneous abort", {map_t, q3_t}, '0);
    idle(W + 2);
    check("R7 no go after abort", {q3_t, go_t, map_t}, '0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule